// File: doc/BRIEF.md
# I2C EEPROM slave controller

This block is the serial front end of a 256-byte nonvolatile memory that sits on a two-wire I2C bus as a slave. It takes the bus clock and data lines after they have been oversampled and synchronised to the system clock. It finds start and stop conditions and matches the device address byte against a fixed type code and three strap inputs. It then either collects write bytes into a small buffer or streams bytes out of its 256-entry storage array. It acknowledges and sends read data through an open-drain enable: when that enable is high, the pad pulls the data line low.

A write transfer carries a word-address byte and then data bytes. Two length rules apply, and a static mode input picks between them. In byte mode up to seven data bytes are accepted and the address steps through the full 256-byte space. In page mode up to eight bytes are accepted and only the low three address bits step, so the address wraps inside an eight-byte page. When a stop ends a clean write, the block gives a separate commit sequencer a one-cycle request. The request carries the buffer, the start address, the byte count and the mode. The sequencer writes the array through a store port and reports busy while it works, and the block will not answer its own address during that time.

Neither data interface has back-pressure. The commit request is a one-cycle pulse, and the sequencer must capture its fields in that cycle. Flow control runs the other way, through the busy input. The store write port accepts one byte in every cycle in which its valid is high.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: A transfer begins only with a start (data falling while clock is high). Bytes clocked without a preceding start are never acknowledged, and a stop (data rising while clock is high) returns the block to idle.
- R2: The first byte after a start is the device address: bits 7..4 must be 1010 and bits 3..1 must equal `dev_sel_i`, with bit 0 as read (1) or write (0). On a match the block pulls data low for the ninth clock. On a mismatch it gives no acknowledge and ignores the bus until the next start.
- R3: While `commit_busy_i` is high, the block does not acknowledge a matching device address.
- R4: In a write, the byte after the device address is the word address, which is acknowledged and loaded as the array pointer. A write with no data bytes requests no commit, but it leaves the pointer for a following read.
- R5: In byte mode (`page_mode_i` low when the word address is received), up to 7 data bytes are acknowledged and the address steps by one modulo 256.
- R6: In page mode, up to 8 data bytes are acknowledged. Only address bits 2..0 step (wrapping from 7 to 0), and bits 7..3 stay fixed.
- R7: A data byte beyond the mode limit (the 8th in byte mode, the 9th in page mode) is not acknowledged. No later byte before the next start is acknowledged, and no commit is requested for that transfer.
- R8: A read sends array bytes MSB first, one bit per clock, starting at the pointer. The pointer steps by one modulo 256 after each byte, and the length is unlimited.
- R9: When the master does not acknowledge a read byte, the block releases data (enable low) and drives nothing more until the next start or stop.
- R10: On a stop that ends a write with at least one accepted data byte and no over-length error, `commit_o` is high for exactly one cycle. `commit_addr_o` is the word address, `commit_count_o` the byte count, `commit_page_o` the mode, and byte i sits at `commit_data_o[8i+7:8i]`.
- R11: A repeated start returns the block to device-address matching and discards uncommitted write data, so no commit follows.
- R12: After reset the data enable is low and no commit request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock level |
| sda_i | input | 1 | Synchronised bus data level |
| dev_sel_i | input | 3 | Static device-select straps |
| page_mode_i | input | 1 | 1 selects page write mode, sampled with the word address |
| commit_busy_i | input | 1 | Commit sequencer busy |
| st_wvalid_i | input | 1 | Store write strobe from the sequencer |
| st_waddr_i | input | 8 | Store write address |
| st_wdata_i | input | 8 | Store write data |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls data low |
| commit_o | output | 1 | One-cycle write commit request |
| commit_page_o | output | 1 | Mode of the committed transfer |
| commit_addr_o | output | 8 | Start word address of the commit |
| commit_count_o | output | 4 | Number of committed bytes |
| commit_data_o | output | 64 | Collected write bytes, byte i at bits 8i+7..8i |

## Verification
The assertions assume that `scl_i` and `sda_i` are already clean synchronised levels. They assume the data line changes only while the clock is low, except at deliberate start and stop conditions, and that the mode and strap inputs hold still during a transfer. The bench drives the bus in quarter-bit steps of several system clocks, and it changes data only while the clock is low, so a data change is never read as a control event. It changes `page_mode_i` and `commit_busy_i` only between transfers. It sweeps all 128 device addresses, and it runs write lengths across both mode limits and reads that wrap the 256-byte space.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  localparam int EE_AW = 8;   // one word-address byte on the bus
  localparam int EE_DW = 8;
  localparam logic [3:0] EE_TYPE_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TACK, ST_IGN
  } ee_state_e;

  typedef enum logic [1:0] {
    K_DEV, K_WADDR, K_WDATA
  } rx_kind_e;
endpackage

// File: rtl/i2c_ee_cond.sv
module i2c_ee_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edges are control events only while the clock stays high
  assign start_o = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2c_ee_pkg::*;
#(
  parameter int BYTE_MAX   = 7,
  parameter int PAGE_BYTES = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 scl_i,
  input  logic                                 sda_i,
  input  logic [2:0]                           dev_sel_i,
  input  logic                                 page_mode_i,
  input  logic                                 commit_busy_i,
  input  logic                                 st_wvalid_i,
  input  logic [EE_AW-1:0]                     st_waddr_i,
  input  logic [EE_DW-1:0]                     st_wdata_i,
  output logic                                 sda_oe_o,
  output logic                                 commit_o,
  output logic                                 commit_page_o,
  output logic [EE_AW-1:0]                     commit_addr_o,
  output logic [$clog2(PAGE_BYTES+1)-1:0]      commit_count_o,
  output logic [PAGE_BYTES*EE_DW-1:0]          commit_data_o
);
  localparam int AW     = EE_AW;
  localparam int DW     = EE_DW;
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int CNT_W  = $clog2(PAGE_BYTES+1);
  localparam int IDX_W  = (PAGE_W > 0) ? PAGE_W : 1;

  logic scl_rise, scl_fall, start_w, stop_w;

  i2c_ee_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_w),
    .stop_o    (stop_w)
  );

  ee_state_e      state;
  rx_kind_e       kind;
  logic [3:0]     bitcnt;
  logic [DW-1:0]  shreg;
  logic           rw;
  logic [AW-1:0]  addr, base;
  logic [CNT_W-1:0] cnt;
  logic           err, pmode, ack_drv;
  logic [DW-1:0]  wbuf [PAGE_BYTES];
  logic [DW-1:0]  rdata;

  i2c_ee_store #(.AW(AW), .DW(DW)) u_store (
    .clk    (clk),
    .we_i   (st_wvalid_i),
    .waddr_i(st_waddr_i),
    .wdata_i(st_wdata_i),
    .raddr_i(addr),
    .rdata_o(rdata)
  );

  logic [CNT_W-1:0] limit;
  logic             byte_done, dev_match, room, wbuf_we;
  logic [AW-1:0]    inc_full, inc_page;

  assign limit     = pmode ? CNT_W'(PAGE_BYTES) : CNT_W'(BYTE_MAX);
  assign byte_done = (state == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign dev_match = (shreg[7:4] == EE_TYPE_CODE) && (shreg[3:1] == dev_sel_i);
  assign room      = cnt < limit;
  assign wbuf_we   = byte_done && (kind == K_WDATA) && room;
  assign inc_full  = addr + AW'(1);
  assign inc_page  = {addr[AW-1:PAGE_W], addr[PAGE_W-1:0] + PAGE_W'(1)};

  always_ff @(posedge clk) begin
    if (wbuf_we) wbuf[cnt[IDX_W-1:0]] <= shreg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      kind           <= K_DEV;
      bitcnt         <= '0;
      shreg          <= '0;
      rw             <= 1'b0;
      addr           <= '0;
      base           <= '0;
      cnt            <= '0;
      err            <= 1'b0;
      pmode          <= 1'b0;
      ack_drv        <= 1'b0;
      commit_o       <= 1'b0;
      commit_page_o  <= 1'b0;
      commit_addr_o  <= '0;
      commit_count_o <= '0;
      commit_data_o  <= '0;
    end else begin
      commit_o <= 1'b0;
      if (start_w) begin
        // fresh or repeated start: back to address matching, drop pending data
        state   <= ST_RX;
        kind    <= K_DEV;
        bitcnt  <= '0;
        cnt     <= '0;
        err     <= 1'b0;
        ack_drv <= 1'b0;
      end else if (stop_w) begin
        state   <= ST_IDLE;
        ack_drv <= 1'b0;
        cnt     <= '0;
        if (kind == K_WDATA && cnt != '0 && !err) begin
          commit_o       <= 1'b1;
          commit_page_o  <= pmode;
          commit_addr_o  <= base;
          commit_count_o <= cnt;
          for (int i = 0; i < PAGE_BYTES; i++)
            commit_data_o[i*DW +: DW] <= wbuf[i];
        end
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[DW-2:0], sda_i};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              bitcnt <= '0;
              unique case (kind)
                K_DEV: begin
                  if (dev_match && !commit_busy_i) begin
                    rw      <= shreg[0];
                    ack_drv <= 1'b1;
                    state   <= ST_ACK;
                  end else begin
                    state <= ST_IGN;
                  end
                end
                K_WADDR: begin
                  addr    <= shreg;
                  base    <= shreg;
                  pmode   <= page_mode_i;
                  ack_drv <= 1'b1;
                  state   <= ST_ACK;
                end
                default: begin
                  if (room) begin
                    cnt     <= cnt + CNT_W'(1);
                    addr    <= pmode ? inc_page : inc_full;
                    ack_drv <= 1'b1;
                    state   <= ST_ACK;
                  end else begin
                    err   <= 1'b1;
                    state <= ST_IGN;
                  end
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              ack_drv <= 1'b0;
              bitcnt  <= '0;
              if (kind == K_DEV && rw) begin
                state <= ST_TX;
                shreg <= rdata;
              end else begin
                state <= ST_RX;
                kind  <= (kind == K_DEV) ? K_WADDR : K_WDATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                state <= ST_TACK;
                addr  <= inc_full;
              end else begin
                shreg  <= {shreg[DW-2:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_TACK: begin
            if (scl_rise && sda_i) begin
              state <= ST_IGN;
            end else if (scl_fall) begin
              state  <= ST_TX;
              shreg  <= rdata;
              bitcnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = ack_drv | ((state == ST_TX) & ~shreg[DW-1]);

  // R10: a commit request only ever follows a stop condition
  assert_commit_after_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(stop_w));

  // R10: committed count is non-zero and within the mode limit
  assert_commit_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (commit_count_o != '0) &&
                 (commit_count_o <= (commit_page_o ? CNT_W'(PAGE_BYTES) : CNT_W'(BYTE_MAX))));

  // R6: page-mode writes never leave the page of the word address
  assert_page_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == K_WDATA && pmode && state != ST_IDLE) |->
      (addr[AW-1:PAGE_W] == base[AW-1:PAGE_W]));

  // R3: a device-address acknowledge never starts while the sequencer was busy
  assert_no_ack_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ack_drv) && kind == K_DEV) |-> !$past(commit_busy_i));

  // R7: accepted byte count never exceeds the active limit
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
endmodule

// File: tb/i2c_eeprom_slave_tb.sv
module i2c_eeprom_slave_tb;
  localparam int Q = 3;
  localparam logic [2:0] SEL = 3'd5;
  localparam logic [7:0] DEV_W = {4'b1010, SEL, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, SEL, 1'b1};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic page_mode = 1'b0, busy = 1'b0;
  logic st_we = 1'b0;
  logic [7:0] st_waddr = '0, st_wdata = '0;
  logic sda_oe, commit;
  logic commit_page;
  logic [7:0] commit_addr;
  logic [3:0] commit_count;
  logic [63:0] commit_data;
  wire sda_bus = sda_m & ~sda_oe;

  i2c_eeprom_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .dev_sel_i(SEL), .page_mode_i(page_mode), .commit_busy_i(busy),
    .st_wvalid_i(st_we), .st_waddr_i(st_waddr), .st_wdata_i(st_wdata),
    .sda_oe_o(sda_oe), .commit_o(commit), .commit_page_o(commit_page),
    .commit_addr_o(commit_addr), .commit_count_o(commit_count),
    .commit_data_o(commit_data)
  );

  int total = 0, fails = 0, ncommit = 0;
  logic [7:0] model [256];
  logic [7:0] wdat [12];
  logic cap_page;
  logic [7:0] cap_addr;
  logic [3:0] cap_cnt;
  logic [63:0] cap_data;

  always @(negedge clk) begin
    if (commit) begin
      ncommit++;
      cap_page = commit_page; cap_addr = commit_addr;
      cap_cnt = commit_count; cap_data = commit_data;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hp(); repeat (Q) @(negedge clk); endtask

  task automatic i2c_start();
    sda_m = 1'b1; hp(); scl = 1'b1; hp(); sda_m = 1'b0; hp(); scl = 1'b0; hp();
  endtask

  task automatic i2c_stop();
    scl = 1'b0; hp(); sda_m = 1'b0; hp(); scl = 1'b1; hp(); sda_m = 1'b1; hp();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hp(); scl = 1'b1; hp(); hp(); scl = 1'b0; hp();
    end
    sda_m = 1'b1; hp(); scl = 1'b1; hp(); ack = (sda_bus == 1'b0); hp(); scl = 1'b0; hp();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      hp(); scl = 1'b1; hp(); d[i] = sda_bus; hp(); scl = 1'b0; hp();
    end
    sda_m = mack ? 1'b0 : 1'b1; hp(); scl = 1'b1; hp(); hp(); scl = 1'b0; hp();
    sda_m = 1'b1;
  endtask

  // write transfer; returns index of first unacknowledged data byte, -1 if none
  task automatic wr_xfer(input logic [7:0] a, input int n, input bit pg, output int nak);
    bit ack;
    page_mode = pg;
    nak = -1;
    i2c_start();
    send_byte(DEV_W, ack); chk(ack, "R2 dev ack", ack, 1);
    send_byte(a, ack);     chk(ack, "R4 waddr ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wdat[i], ack);
      if (!ack && nak < 0) nak = i;
    end
    i2c_stop();
    repeat (4) @(negedge clk);
  endtask

  task automatic apply_commit();
    logic [7:0] a;
    busy = 1'b1;
    for (int i = 0; i < int'(cap_cnt); i++) begin
      a = cap_page ? {cap_addr[7:3], 3'(cap_addr[2:0] + 3'(i))} : 8'(cap_addr + 8'(i));
      @(negedge clk);
      st_we = 1'b1; st_waddr = a; st_wdata = cap_data[i*8 +: 8];
      model[a] = cap_data[i*8 +: 8];
    end
    @(negedge clk); st_we = 1'b0; busy = 1'b0;
  endtask

  task automatic rd_random(input logic [7:0] a, input int n, input string req);
    bit ack;
    logic [7:0] d;
    i2c_start();
    send_byte(DEV_W, ack);
    send_byte(a, ack);
    i2c_start();
    send_byte(DEV_R, ack); chk(ack, "R11 read dev ack after repeated start", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == model[8'(a + 8'(i))], req, d, model[8'(a + 8'(i))]);
    end
    i2c_stop();
  endtask

  initial begin
    bit ack;
    int nak, c0;
    logic [7:0] d, base;

    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R12 reset sda_oe", sda_oe, 0);
    chk(commit == 1'b0, "R12 reset commit", commit, 0);
    rst_n = 1'b1;
    for (int a = 0; a < 256; a++) begin
      @(negedge clk); st_we = 1'b1; st_waddr = 8'(a); st_wdata = 8'(a * 7 + 3);
      model[a] = 8'(a * 7 + 3);
    end
    @(negedge clk); st_we = 1'b0;

    // R1: a byte with no start is never acknowledged
    send_byte(DEV_W, ack);
    chk(!ack, "R1 no ack without start", ack, 0);

    // R2/R4: sweep all device addresses, write direction
    c0 = ncommit;
    for (int a = 0; a < 128; a++) begin
      i2c_start();
      send_byte({7'(a), 1'b0}, ack);
      chk(ack == (7'(a) == DEV_W[7:1]), "R2 address match", ack, 7'(a) == DEV_W[7:1]);
      send_byte(DEV_W, ack);
      chk(ack == (7'(a) == DEV_W[7:1]), "R2 ignore until start", ack, 7'(a) == DEV_W[7:1]);
      i2c_stop();
    end
    chk(ncommit == c0, "R4 address-only write no commit", ncommit, c0);

    // R5/R10: byte-mode writes of 1..7 bytes, last one wraps past 0xFF
    for (int n = 1; n <= 7; n++) begin
      base = (n == 7) ? 8'hFB : 8'(n * 20);
      for (int i = 0; i < n; i++) wdat[i] = 8'((n * 16 + i) ^ 8'h5A);
      c0 = ncommit;
      wr_xfer(base, n, 1'b0, nak);
      chk(nak == -1, "R5 all data acked", nak, -1);
      chk(ncommit == c0 + 1, "R10 one commit pulse", ncommit, c0 + 1);
      chk(cap_addr == base && cap_cnt == 4'(n) && !cap_page, "R10 commit fields",
          {cap_page, cap_cnt, cap_addr}, {1'b0, 4'(n), base});
      for (int i = 0; i < n; i++)
        chk(cap_data[i*8 +: 8] == wdat[i], "R10 commit byte", cap_data[i*8 +: 8], wdat[i]);
      apply_commit();
      rd_random(base, n, "R5 readback");
    end

    // R7: eighth byte in byte mode refused
    for (int i = 0; i < 9; i++) wdat[i] = 8'(8'hC0 + i);
    c0 = ncommit;
    wr_xfer(8'h10, 9, 1'b0, nak);
    chk(nak == 7, "R7 byte mode nack index", nak, 7);
    chk(ncommit == c0, "R7 byte mode no commit", ncommit, c0);
    rd_random(8'h10, 8, "R7 memory unchanged");

    // R6: page writes with in-page wrap
    for (int i = 0; i < 8; i++) wdat[i] = 8'(8'h90 + i * 3);
    c0 = ncommit;
    wr_xfer(8'h3D, 8, 1'b1, nak);
    chk(nak == -1, "R6 eight bytes acked", nak, -1);
    chk(ncommit == c0 + 1 && cap_page && cap_cnt == 4'd8 && cap_addr == 8'h3D,
        "R6 page commit", {cap_page, cap_cnt, cap_addr}, {1'b1, 4'd8, 8'h3D});
    apply_commit();
    rd_random(8'h38, 8, "R6 page readback");
    for (int i = 0; i < 3; i++) wdat[i] = 8'(8'h11 * (i + 1));
    wr_xfer(8'h3E, 3, 1'b1, nak);
    apply_commit();
    chk(model[8'h38] == 8'h33, "R6 wrap to page start", model[8'h38], 8'h33);
    rd_random(8'h38, 8, "R6 wrap readback");

    // R7: ninth page byte refused, whole transfer dropped
    for (int i = 0; i < 10; i++) wdat[i] = 8'(8'hE0 + i);
    c0 = ncommit;
    wr_xfer(8'h80, 10, 1'b1, nak);
    chk(nak == 8, "R7 page nack index", nak, 8);
    chk(ncommit == c0, "R7 page no commit", ncommit, c0);
    rd_random(8'h80, 8, "R7 page memory unchanged");

    // R3: busy blocks the device address
    busy = 1'b1;
    i2c_start();
    send_byte(DEV_W, ack); chk(!ack, "R3 busy no ack", ack, 0);
    i2c_stop();
    busy = 1'b0;
    i2c_start();
    send_byte(DEV_R, ack); chk(ack, "R3 ack after busy clears", ack, 1);
    recv_byte(1'b0, d);
    i2c_stop();

    // R8: read across the top of the array, then current-address read
    rd_random(8'hFD, 6, "R8 wrapping read");
    i2c_start();
    send_byte(DEV_R, ack);
    recv_byte(1'b1, d); chk(d == model[8'h03], "R8 current address read", d, model[8'h03]);
    recv_byte(1'b0, d); chk(d == model[8'h04], "R8 current address next", d, model[8'h04]);
    // R9: after master nack the line stays released
    for (int k = 0; k < 9; k++) begin
      hp(); scl = 1'b1; hp();
      if (sda_oe) chk(1'b0, "R9 released after nack", sda_oe, 0);
      hp(); scl = 1'b0; hp();
    end
    chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
    i2c_stop();

    // R11: repeated start drops pending write data
    page_mode = 1'b0;
    c0 = ncommit;
    i2c_start();
    send_byte(DEV_W, ack);
    send_byte(8'h50, ack);
    send_byte(8'hAA, ack);
    send_byte(8'h55, ack);
    i2c_start();
    send_byte(DEV_R, ack); chk(ack, "R11 dev ack after repeated start", ack, 1);
    recv_byte(1'b0, d); chk(d == model[8'h52], "R11 read continues at pointer", d, model[8'h52]);
    i2c_stop();
    repeat (4) @(negedge clk);
    chk(ncommit == c0, "R11 no commit", ncommit, c0);

    // R4: address-only write sets the read pointer
    i2c_start();
    send_byte(DEV_W, ack);
    send_byte(8'h77, ack);
    i2c_stop();
    i2c_start();
    send_byte(DEV_R, ack);
    recv_byte(1'b0, d); chk(d == model[8'h77], "R4 pointer from address-only write", d, model[8'h77]);
    i2c_stop();
    chk(ncommit == c0, "R4 no commit", ncommit, c0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule